// File: doc/BRIEF.md
# Flash chip presence and capacity scanner

After reset this block walks the chip-select lines that a build parameter enables. It goes from the lowest line to the highest. On each line it sends the read-identification opcode and collects four reply bytes. From the manufacturer byte and the capacity code it decides whether a serial flash device answers on that line and how many 64 KiB erase sectors it holds.

Devices that answer are packed into a table in select-line order. Each entry holds the line's one-hot select mask and its sector count. When every line has been probed, the block reports several values:
- the chip count
- the total capacity in bytes
- the erase block size
- the read/write unit
- the byte offset of a configuration region that occupies the last erase block
- a done flag, with a flag for the case where nothing was found

The serial shifting itself belongs to a shared SPI engine. The block asks for one byte at a time through a level request. The request carries the select mask, the byte to send and an end-of-frame marker. The engine accepts a byte with a one-cycle acknowledge pulse that returns the received byte. The table then serves as the address map for the command sequencer that issues reads, programs and erases.

Top module: `flash_chip_scan`

## Requirements
- R1: Probes visit only the lines set in CS_ENABLE (default 4'b1101), in ascending line order. Each request carries a one-hot select mask (bit n = line n), and a disabled line is never selected.
- R2: Each probe is five byte transfers on one select line. The first sends 0x9F and the next four send 0xFF. The end-of-frame marker is high only on the fifth transfer.
- R3: A request that has not been acknowledged keeps its request level, select mask, transmit byte and end marker unchanged until the acknowledge arrives.
- R4: A line whose first reply byte (manufacturer) is 0xFF is treated as empty and adds no table entry, whatever its other bytes are.
- R5: A line whose third reply byte (capacity code) is below 0x11 or above 0x1F is treated as empty.
- R6: A present chip's sector count is 1 << (code - 0x10): 0x11 gives 2 and 0x1F gives 32768.
- R7: Present chips fill table entries 0, 1, ... in line order. Entry i holds mask bits [i*NUM_CS +: NUM_CS] and sectors [i*SECT_W +: SECT_W]. The chip count equals the number filled, and unused entries read zero.
- R8: The total capacity in bytes equals the sum of the sector counts times 65536. The block size output reads 65536 and the unit output reads 256.
- R9: The configuration offset equals the total capacity minus 65536 when at least one chip is present.
- R10: The done flag rises only after the last enabled line is probed. It then stays high, and no further requests are issued.
- R11: When no chip is present, done comes with the no-device flag, a total of 0 and a configuration offset of 0. The no-device flag is low whenever at least one chip is present.
- R12: While reset is asserted, the done flag, the no-device flag, the request, the chip count and the total are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low; a scan starts on release |
| spi_req_o | output | 1 | Byte transfer request to the shared SPI engine |
| spi_cs_o | output | NUM_CS | One-hot select mask for the requested byte |
| spi_tx_o | output | 8 | Byte to send |
| spi_end_o | output | 1 | Release the select after this byte |
| spi_ack_i | input | 1 | One-cycle pulse: byte accepted and received |
| spi_rx_i | input | 8 | Received byte, valid with spi_ack_i |
| tbl_mask_o | output | NUM_CS*NUM_CS | Packed table of select masks |
| tbl_sect_o | output | NUM_CS*SECT_W | Packed table of sector counts |
| chip_count_o | output | CNT_W | Number of chips found |
| total_bytes_o | output | TOT_W+16 | Total capacity in bytes |
| config_base_o | output | TOT_W+16 | Byte offset of the configuration block |
| block_bytes_o | output | 17 | Erase block size in bytes |
| unit_bytes_o | output | 9 | Read/write unit in bytes |
| scan_done_o | output | 1 | Scan complete |
| no_dev_o | output | 1 | Scan complete and no chip found |

## Verification
The hardest situations to reach from the ports are a present chip on a line that follows an empty one, and codes sitting exactly on the range edges. In the first case the table must pack entries without gaps. In the second, a manufacturer byte of 0xFF must override an otherwise valid code.

The bench plays the SPI engine and answers each probe from a per-line reply table that it fills before every scan. Directed cases put 0x10, 0x11, 0x1F, 0x20 and 0xFF patterns on chosen lines. Seeded random cases bias codes toward the boundary window. Random acknowledge delays exercise the hold rule, and the disabled line holds a valid reply that must never be read.

// File: rtl/flash_scan_pkg.sv
package flash_scan_pkg;
  localparam logic [7:0] OP_READ_ID = 8'h9F;
  localparam logic [7:0] FILL_BYTE  = 8'hFF;
  localparam logic [7:0] NO_CHIP    = 8'hFF;
  localparam logic [7:0] CAP_MIN    = 8'h11;
  localparam logic [7:0] CAP_MAX    = 8'h1F;
  localparam logic [7:0] CAP_BASE   = 8'h10;

  localparam int unsigned REPLY_LEN   = 4;
  localparam int unsigned MANUF_IDX   = 0;
  localparam int unsigned CAP_IDX     = 2;
  localparam int unsigned BLOCK_SHIFT = 16;
  localparam int unsigned UNIT_BYTES  = 256;

  typedef enum logic [2:0] {
    ST_FIND,
    ST_CMD,
    ST_RX,
    ST_COMMIT,
    ST_DONE
  } scan_state_e;
endpackage

// File: rtl/flash_scan_seq.sv
module flash_scan_seq
  import flash_scan_pkg::*;
#(
  parameter int unsigned NUM_CS = 4,
  parameter logic [NUM_CS-1:0] CS_ENABLE = '1,
  localparam int unsigned LINE_W = $clog2(NUM_CS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              spi_req_o,
  output logic [NUM_CS-1:0] spi_cs_o,
  output logic [7:0]        spi_tx_o,
  output logic              spi_end_o,
  input  logic              spi_ack_i,
  input  logic [7:0]        spi_rx_i,
  output logic [7:0]        manuf_o,
  output logic [7:0]        cap_o,
  output logic [NUM_CS-1:0] line_mask_o,
  output logic              commit_o,
  output logic              done_o
);
  localparam logic [NUM_CS:0] EN_EXT = {1'b0, CS_ENABLE};
  localparam logic [1:0] LAST_BYTE = 2'(REPLY_LEN - 1);

  scan_state_e state_q;
  logic [LINE_W-1:0] line_q;
  logic [1:0] byte_q;
  logic [7:0] manuf_q, cap_q;
  logic [NUM_CS-1:0] line_hot;

  always_comb begin
    for (int i = 0; i < NUM_CS; i++) line_hot[i] = (line_q == LINE_W'(i));
  end

  assign spi_req_o   = (state_q == ST_CMD) || (state_q == ST_RX);
  assign spi_cs_o    = line_hot;
  assign spi_tx_o    = (state_q == ST_CMD) ? OP_READ_ID : FILL_BYTE;
  assign spi_end_o   = (state_q == ST_RX) && (byte_q == LAST_BYTE);
  assign manuf_o     = manuf_q;
  assign cap_o       = cap_q;
  assign line_mask_o = line_hot;
  assign commit_o    = (state_q == ST_COMMIT);
  assign done_o      = (state_q == ST_DONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_FIND;
      line_q  <= '0;
      byte_q  <= '0;
      manuf_q <= '0;
      cap_q   <= '0;
    end else begin
      unique case (state_q)
        ST_FIND: begin
          if (line_q == LINE_W'(NUM_CS)) state_q <= ST_DONE;
          else if (EN_EXT[line_q]) state_q <= ST_CMD;
          else line_q <= line_q + 1'b1;
        end
        ST_CMD: begin
          if (spi_ack_i) begin
            state_q <= ST_RX;
            byte_q  <= '0;
          end
        end
        ST_RX: begin
          if (spi_ack_i) begin
            if (byte_q == 2'(MANUF_IDX)) manuf_q <= spi_rx_i;
            if (byte_q == 2'(CAP_IDX)) cap_q <= spi_rx_i;
            if (byte_q == LAST_BYTE) state_q <= ST_COMMIT;
            else byte_q <= byte_q + 1'b1;
          end
        end
        ST_COMMIT: begin
          line_q  <= line_q + 1'b1;
          state_q <= ST_FIND;
        end
        default: state_q <= ST_DONE;
      endcase
    end
  end
endmodule

// File: rtl/flash_id_decode.sv
module flash_id_decode
  import flash_scan_pkg::*;
#(
  parameter int unsigned SECT_W = 16
) (
  input  logic [7:0]        manuf_i,
  input  logic [7:0]        cap_i,
  output logic              present_o,
  output logic [SECT_W-1:0] sectors_o
);
  logic [7:0] shamt;

  assign shamt     = cap_i - CAP_BASE;
  assign present_o = (manuf_i != NO_CHIP) && (cap_i >= CAP_MIN) && (cap_i <= CAP_MAX);
  assign sectors_o = present_o ? (SECT_W'(1) << shamt[3:0]) : '0;
endmodule

// File: rtl/flash_chip_table.sv
module flash_chip_table #(
  parameter int unsigned NUM_CS = 4,
  parameter int unsigned SECT_W = 16,
  localparam int unsigned CNT_W = $clog2(NUM_CS + 1),
  localparam int unsigned TOT_W = SECT_W + $clog2(NUM_CS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       commit_i,
  input  logic                       present_i,
  input  logic [NUM_CS-1:0]          mask_i,
  input  logic [SECT_W-1:0]          sectors_i,
  output logic [NUM_CS*NUM_CS-1:0]   tbl_mask_o,
  output logic [NUM_CS*SECT_W-1:0]   tbl_sect_o,
  output logic [CNT_W-1:0]           count_o,
  output logic [TOT_W-1:0]           total_sect_o
);
  logic wr;
  logic [CNT_W-1:0] count_q;
  logic [TOT_W-1:0] total_q;

  assign wr = commit_i && present_i;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_entry
    logic [NUM_CS-1:0] mask_q;
    logic [SECT_W-1:0] sect_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mask_q <= '0;
        sect_q <= '0;
      end else if (wr && count_q == CNT_W'(g)) begin
        mask_q <= mask_i;
        sect_q <= sectors_i;
      end
    end
    assign tbl_mask_o[g*NUM_CS +: NUM_CS] = mask_q;
    assign tbl_sect_o[g*SECT_W +: SECT_W] = sect_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      total_q <= '0;
    end else if (wr) begin
      count_q <= count_q + 1'b1;
      total_q <= total_q + TOT_W'(sectors_i);
    end
  end

  assign count_o      = count_q;
  assign total_sect_o = total_q;
endmodule

// File: rtl/flash_chip_scan.sv
module flash_chip_scan
  import flash_scan_pkg::*;
#(
  parameter int unsigned NUM_CS = 4,
  parameter logic [NUM_CS-1:0] CS_ENABLE = 4'b1101,
  parameter int unsigned SECT_W = 16,
  localparam int unsigned CNT_W = $clog2(NUM_CS + 1),
  localparam int unsigned TOT_W = SECT_W + $clog2(NUM_CS),
  localparam int unsigned BYTES_W = TOT_W + BLOCK_SHIFT
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  output logic                     spi_req_o,
  output logic [NUM_CS-1:0]        spi_cs_o,
  output logic [7:0]               spi_tx_o,
  output logic                     spi_end_o,
  input  logic                     spi_ack_i,
  input  logic [7:0]               spi_rx_i,
  output logic [NUM_CS*NUM_CS-1:0] tbl_mask_o,
  output logic [NUM_CS*SECT_W-1:0] tbl_sect_o,
  output logic [CNT_W-1:0]         chip_count_o,
  output logic [BYTES_W-1:0]       total_bytes_o,
  output logic [BYTES_W-1:0]       config_base_o,
  output logic [BLOCK_SHIFT:0]     block_bytes_o,
  output logic [8:0]               unit_bytes_o,
  output logic                     scan_done_o,
  output logic                     no_dev_o
);
  logic [7:0] manuf, cap;
  logic [NUM_CS-1:0] line_mask;
  logic commit, done, present;
  logic [SECT_W-1:0] sectors;
  logic [TOT_W-1:0] total_sect;

  flash_scan_seq #(.NUM_CS(NUM_CS), .CS_ENABLE(CS_ENABLE)) u_seq (
    .clk_i, .rst_ni,
    .spi_req_o, .spi_cs_o, .spi_tx_o, .spi_end_o, .spi_ack_i, .spi_rx_i,
    .manuf_o(manuf), .cap_o(cap), .line_mask_o(line_mask),
    .commit_o(commit), .done_o(done)
  );

  flash_id_decode #(.SECT_W(SECT_W)) u_dec (
    .manuf_i(manuf), .cap_i(cap), .present_o(present), .sectors_o(sectors)
  );

  flash_chip_table #(.NUM_CS(NUM_CS), .SECT_W(SECT_W)) u_tbl (
    .clk_i, .rst_ni,
    .commit_i(commit), .present_i(present), .mask_i(line_mask), .sectors_i(sectors),
    .tbl_mask_o, .tbl_sect_o, .count_o(chip_count_o), .total_sect_o(total_sect)
  );

  assign total_bytes_o = {total_sect, {BLOCK_SHIFT{1'b0}}};
  // configuration region lives in the final erase block
  assign config_base_o = (total_sect != '0) ? {total_sect - 1'b1, {BLOCK_SHIFT{1'b0}}} : '0;
  assign block_bytes_o = (BLOCK_SHIFT+1)'(1) << BLOCK_SHIFT;
  assign unit_bytes_o  = 9'(UNIT_BYTES);
  assign scan_done_o   = done;
  assign no_dev_o      = done && (chip_count_o == '0);
endmodule

// File: rtl/flash_chip_scan_chk.sv
module flash_chip_scan_chk #(
  parameter int unsigned NUM_CS = 4,
  parameter logic [NUM_CS-1:0] CS_ENABLE = '1,
  parameter int unsigned CNT_W = 3,
  parameter int unsigned BYTES_W = 34
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               spi_req_o,
  input logic [NUM_CS-1:0]  spi_cs_o,
  input logic [7:0]         spi_tx_o,
  input logic               spi_end_o,
  input logic               spi_ack_i,
  input logic [CNT_W-1:0]   chip_count_o,
  input logic [BYTES_W-1:0] total_bytes_o,
  input logic               scan_done_o,
  input logic               no_dev_o
);
  // R1
  cs_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_req_o |-> $onehot(spi_cs_o));
  // R1
  cs_enabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_req_o |-> ((spi_cs_o & ~CS_ENABLE) == '0));
  // R2
  end_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spi_req_o && spi_end_o) |-> (spi_tx_o == 8'hFF));
  // R3
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spi_req_o && !spi_ack_i) |=> (spi_req_o && $stable(spi_cs_o) && $stable(spi_tx_o) && $stable(spi_end_o)));
  // R7
  count_mono_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_done_o |=> (chip_count_o == $past(chip_count_o)));
  // R8
  total_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chip_count_o == '0) == (total_bytes_o == '0));
  // R10
  done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_done_o |=> scan_done_o);
  // R10
  done_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_done_o |-> !spi_req_o);
  // R11
  nodev_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    no_dev_o |-> (scan_done_o && total_bytes_o == '0));
endmodule

bind flash_chip_scan flash_chip_scan_chk #(
  .NUM_CS(NUM_CS), .CS_ENABLE(CS_ENABLE), .CNT_W(CNT_W), .BYTES_W(BYTES_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .spi_req_o(spi_req_o), .spi_cs_o(spi_cs_o),
  .spi_tx_o(spi_tx_o), .spi_end_o(spi_end_o), .spi_ack_i(spi_ack_i),
  .chip_count_o(chip_count_o), .total_bytes_o(total_bytes_o),
  .scan_done_o(scan_done_o), .no_dev_o(no_dev_o)
);

// File: tb/flash_chip_scan_tb.sv
module flash_chip_scan_tb;
  localparam int NUM_CS = 4;
  localparam logic [NUM_CS-1:0] EN = 4'b1101;
  localparam int SECT_W = 16;
  localparam int CNT_W = 3;
  localparam int BYTES_W = 34;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_req, spi_end, spi_ack = 1'b0;
  logic [NUM_CS-1:0] spi_cs;
  logic [7:0] spi_tx, spi_rx = 8'h00;
  logic [NUM_CS*NUM_CS-1:0] tbl_mask;
  logic [NUM_CS*SECT_W-1:0] tbl_sect;
  logic [CNT_W-1:0] chip_count;
  logic [BYTES_W-1:0] total_bytes, config_base;
  logic [16:0] block_bytes;
  logic [8:0] unit_bytes;
  logic scan_done, no_dev;

  always #5 clk = ~clk;

  flash_chip_scan u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .spi_req_o(spi_req), .spi_cs_o(spi_cs), .spi_tx_o(spi_tx), .spi_end_o(spi_end),
    .spi_ack_i(spi_ack), .spi_rx_i(spi_rx),
    .tbl_mask_o(tbl_mask), .tbl_sect_o(tbl_sect), .chip_count_o(chip_count),
    .total_bytes_o(total_bytes), .config_base_o(config_base),
    .block_bytes_o(block_bytes), .unit_bytes_o(unit_bytes),
    .scan_done_o(scan_done), .no_dev_o(no_dev)
  );

  int checks = 0;
  int fails = 0;
  logic [7:0] rep [NUM_CS][4];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int en_line(input int p);
    int n = 0;
    for (int l = 0; l < NUM_CS; l++) begin
      if (EN[l]) begin
        if (n == p) return l;
        n++;
      end
    end
    return -1;
  endfunction

  function automatic longint sect_of(input int l);
    if (rep[l][0] == 8'hFF) return 0;
    if (rep[l][2] < 8'h11 || rep[l][2] > 8'h1F) return 0;
    return longint'(1) << (rep[l][2] - 8'h10);
  endfunction

  task automatic set_line(input int l, input logic [7:0] m, input logic [7:0] c);
    rep[l][0] = m; rep[l][1] = 8'h20; rep[l][2] = c; rep[l][3] = 8'h5A;
  endtask

  task automatic run_case(input string tag);
    bit hung = 0;
    int cyc = 0, probe = 0, k = 0, line;
    int n_exp = 0;
    longint tot = 0;
    rst_n = 1'b0;
    spi_ack = 1'b0;
    repeat (2) @(negedge clk);
    // R12
    chk(!scan_done && !no_dev && !spi_req && chip_count == 0 && total_bytes == 0,
        "R12", "reset state", {scan_done, no_dev, spi_req}, 0);
    rst_n = 1'b1;
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc > 5000) begin hung = 1; break; end
      if (scan_done) break;
      if (spi_req) begin
        automatic int d = $urandom % 3;
        repeat (d) @(negedge clk);
        line = en_line(probe);
        chk(line >= 0 && spi_cs == NUM_CS'(1 << line), "R1", "select mask", spi_cs,
            (line >= 0) ? (1 << line) : 0);
        chk(spi_tx == ((k == 0) ? 8'h9F : 8'hFF), "R2", "tx byte", spi_tx,
            (k == 0) ? 8'h9F : 8'hFF);
        chk(spi_end == (k == 4), "R2", "end marker", spi_end, (k == 4));
        spi_rx = (k == 0 || line < 0) ? 8'h00 : rep[line][k-1];
        spi_ack = 1'b1;
        @(negedge clk);
        spi_ack = 1'b0;
        if (k == 4) begin k = 0; probe++; end
        else k++;
      end
    end
    chk(!hung, "R10", "watchdog", hung, 0);
    chk(probe == $countones(EN) && k == 0, "R10", "probe count", probe, $countones(EN));
    @(negedge clk);
    chk(scan_done && !spi_req, "R10", "done held, quiet", {scan_done, spi_req}, 2'b10);
    for (int l = 0; l < NUM_CS; l++) begin
      if (EN[l] && sect_of(l) != 0) begin
        chk(tbl_mask[n_exp*NUM_CS +: NUM_CS] == NUM_CS'(1 << l), "R7", "entry mask",
            tbl_mask[n_exp*NUM_CS +: NUM_CS], 1 << l);
        chk(tbl_sect[n_exp*SECT_W +: SECT_W] == SECT_W'(sect_of(l)), "R6", "entry sectors",
            tbl_sect[n_exp*SECT_W +: SECT_W], sect_of(l));
        tot += sect_of(l);
        n_exp++;
      end
    end
    for (int e = n_exp; e < NUM_CS; e++) begin
      chk(tbl_mask[e*NUM_CS +: NUM_CS] == 0 && tbl_sect[e*SECT_W +: SECT_W] == 0,
          "R7", "unused entry", tbl_sect[e*SECT_W +: SECT_W], 0);
    end
    chk(chip_count == CNT_W'(n_exp), tag, "chip count", chip_count, n_exp);
    chk(total_bytes == BYTES_W'(tot * 65536), "R8", "total bytes", total_bytes, tot * 65536);
    chk(block_bytes == 17'd65536 && unit_bytes == 9'd256, "R8", "block/unit",
        block_bytes, 65536);
    chk(config_base == BYTES_W'((tot == 0) ? 0 : (tot - 1) * 65536), "R9", "config base",
        config_base, (tot == 0) ? 0 : (tot - 1) * 65536);
    chk(no_dev == (n_exp == 0), "R11", "no-device flag", no_dev, (n_exp == 0));
  endtask

  initial begin : watchdog
    #1900000;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    // all empty; line 1 disabled but holds a valid reply
    for (int l = 0; l < NUM_CS; l++) set_line(l, 8'hFF, 8'hFF);
    set_line(1, 8'h20, 8'h14);
    run_case("R11");
    // range edges: 0x10 and 0x20 rejected, 0x11 and 0x1F accepted
    set_line(0, 8'h20, 8'h10); set_line(2, 8'h20, 8'h11); set_line(3, 8'hC2, 8'h1F);
    run_case("R5");
    set_line(0, 8'h20, 8'h20); set_line(2, 8'hEF, 8'h1F); set_line(3, 8'h20, 8'h11);
    run_case("R5");
    // valid code but manufacturer 0xFF; present chip after empty line
    set_line(0, 8'hFF, 8'h14); set_line(2, 8'hFF, 8'h13); set_line(3, 8'h20, 8'h14);
    run_case("R4");
    set_line(0, 8'h20, 8'h14); set_line(2, 8'h20, 8'h12); set_line(3, 8'h01, 8'h15);
    run_case("R6");
    for (int it = 0; it < 25; it++) begin
      for (int l = 0; l < NUM_CS; l++) begin
        rep[l][0] = ($urandom % 4 == 0) ? 8'hFF : 8'($urandom);
        rep[l][1] = 8'($urandom);
        rep[l][2] = ($urandom % 5 == 0) ? 8'($urandom) : 8'(8'h0F + $urandom % 19);
        rep[l][3] = 8'($urandom);
      end
      run_case("R7");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule